// File: doc/BRIEF.md
# Serial Flash Phase Sequencer

This block runs one serial-flash transaction on a bus of up to four IO lines. Before a transaction, the controlling logic sets up the configuration inputs. These cover the command bytes, address, option bytes, dummy length, data masks and a line-width code for each phase. The controlling logic then pulses `start`. The sequencer asserts chip select and then walks through the enabled phases in a fixed order: first command byte, second command byte, address, option, dummy, data. Each bit slot lasts two clocks, with the serial clock low for one clock and high for one. The transaction ends by releasing chip select and raising the transfer-end flag.

Write data is shifted out of `wdata`. Read data is sampled into `rdata`, left-aligned. A keep-select mode leaves chip select asserted after the transfer. The next `start` then continues the same transaction with its data phase only, so one long transfer can be split into 4-byte chunks.

The controller has four states. `ST_IDLE` waits for `start`. `ST_LEAD` holds chip select before the first clock. `ST_SHIFT` runs bit slots for the current phase. `ST_TRAIL` holds chip select after the last clock. The transitions are:
- idle to lead: a new `start`.
- idle to shift: a continuation `start` while select is held.
- lead to shift: the lead delay expires.
- shift to shift: the next enabled phase is loaded.
- shift to trail: the last phase ends without keep-select.
- shift to idle: the last phase ends with keep-select.
- trail to idle: the trail delay expires.

Configuration inputs must stay stable while a transfer is running.

Top module: `sflash_phase_seq`

## Requirements
- R1: Only enabled phases run, always in the order first command, second command, address, option, dummy, data. A phase with a zero byte mask, or data with neither `rd_en` nor `wr_en`, is skipped.
- R2: Width code 0 uses one line, code 1 uses two lines and code 2 uses four lines (`io[0]`, `io[1:0]`, `io[3:0]`). Each slot carries the next most significant bits, with the highest of them on the highest line. `sck` is low for one clock and then high for one clock per slot.
- R3: The first command byte is taken from `cmd_reg[23:16]` and the second from `cmd_reg[7:0]`, each 8 bits.
- R4: Address mask bit i selects `addr_reg[8i+7:8i]`. Selected bytes are sent highest index first, and a zero mask removes the address phase.
- R5: Option mask bit i selects `opt_reg[8i+7:8i]` with the same ordering. MSB-filled masks 1000, 1100, 1110 and 1111 send 1, 2, 3 and 4 bytes.
- R6: With `dummy_en` set, the dummy phase runs `dummy_cyc`+1 slots with `io_oe` all zero.
- R7: A write sends the data bytes chosen by `data_mask` from `wdata`. Mask 1000 sends `wdata[31:24]` and mask 1100 sends `wdata[31:16]`.
- R8: A read samples `io_in` on the lines of its width each time `sck` rises, with `io_oe` zero. At the end `rdata` holds the bytes left-aligned from bit 31, with lower bits zero.
- R9: `cs_n` falls `lead_dly`+2 clocks before the first rising `sck`.
- R10: Without keep-select, `cs_n` rises `trail_dly`+1 clocks after the last falling `sck`, and `xfer_end` rises on the same edge.
- R11: With `keep_cs` set, `cs_n` stays low and `cs_active` stays high after the transfer, and `xfer_end` is set. The next `start` runs only the data phase, with no lead delay.
- R12: `xfer_end` is zero on the cycle after an accepted `start`. `cs_active` is high exactly while `cs_n` is low.
- R13: After reset, `cs_n` is 1, `sck` is 0, `io_oe` is 0, and `xfer_end` and `cs_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | start pulse |
| rd_en | input | 1 | data phase reads |
| wr_en | input | 1 | data phase writes |
| keep_cs | input | 1 | hold select after this transfer |
| lead_dly | input | 3 | select-to-clock delay |
| trail_dly | input | 3 | clock-to-release delay |
| cmd_en | input | 1 | first command enable |
| cmd2_en | input | 1 | second command enable |
| cmd_w | input | 2 | first command width code |
| cmd2_w | input | 2 | second command width code |
| addr_w | input | 2 | address width code |
| opt_w | input | 2 | option width code |
| data_w | input | 2 | data width code |
| addr_mask | input | 4 | address byte mask |
| opt_mask | input | 4 | option byte mask |
| data_mask | input | 4 | data byte mask |
| dummy_en | input | 1 | dummy phase enable |
| dummy_cyc | input | 5 | dummy slots minus one |
| cmd_reg | input | 32 | command bytes |
| addr_reg | input | 32 | address bytes |
| opt_reg | input | 32 | option bytes |
| wdata | input | 32 | write data |
| io_in | input | 4 | IO lines in |
| sck | output | 1 | serial clock |
| cs_n | output | 1 | chip select, active low |
| io_out | output | 4 | IO lines out |
| io_oe | output | 4 | IO output enables |
| rdata | output | 32 | read data |
| xfer_end | output | 1 | transfer-end flag |
| cs_active | output | 1 | select state flag |

## Verification
Outputs are decoded from registers, so each result appears one clock after the edge that causes it. The bench therefore samples at the falling clock edge.

- Serial clock: the first rising `sck` appears `lead_dly`+2 clocks after `cs_n` falls.
- Chip-select release: `cs_n` rises `trail_dly`+2 clocks after the last `sck` high sample, on the same edge as `xfer_end`.
- Read data: `rdata` is valid on that edge, or on the end edge for a kept select.
- Flag clear: `xfer_end` must read zero one clock after `start` is accepted.

The bench records the IO lines at every high `sck` slot and drives read data one slot ahead of the sampling edge. After `xfer_end`, it waits two clocks before comparing the timestamps, so that the monitor has caught the release edge.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_CMD2  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_OPT   = 3'd3,
        PH_DUMMY = 3'd4,
        PH_DATA  = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } state_t;

    localparam int NPH = 6;

    // bytes picked by mask bit i come from src[8i+:8], highest index first, left-aligned
    function automatic logic [31:0] pack_bytes(input logic [31:0] src, input logic [3:0] mask);
        logic [31:0] w;
        int n;
        w = '0;
        n = 0;
        for (int i = 3; i >= 0; i--) begin
            if (mask[i]) begin
                w[31 - 8*n -: 8] = src[8*i +: 8];
                n++;
            end
        end
        return w;
    endfunction

    function automatic logic [2:0] lines_of(input logic [1:0] code);
        return (code == 2'd0) ? 3'd1 : (code == 2'd1) ? 3'd2 : 3'd4;
    endfunction

    function automatic logic [1:0] lsh_of(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/sfq_phase_pick.sv
module sfq_phase_pick
    import sfq_pkg::*;
(
    input  logic [NPH-1:0]       phase_on,
    input  logic [3:0]           base,
    input  logic [NPH-1:0][1:0]  w_code,
    input  logic [NPH-1:0][31:0] ph_word,
    input  logic [NPH-1:0][2:0]  ph_bytes,
    input  logic [4:0]           dummy_cyc,
    output logic                 found,
    output phase_t               pick,
    output logic [31:0]          word,
    output logic [5:0]           slots,
    output logic [1:0]           code
);
    // lowest enabled phase at or above base wins
    always_comb begin
        found = 1'b0;
        pick  = PH_DATA;
        for (int i = NPH - 1; i >= 0; i--) begin
            if (4'(i) >= base && phase_on[i]) begin
                found = 1'b1;
                pick  = phase_t'(3'(i));
            end
        end
        code = w_code[pick];
        word = ph_word[pick];
        if (pick == PH_DUMMY)
            slots = {1'b0, dummy_cyc};
        else
            slots = (6'({ph_bytes[pick], 3'b000}) >> lsh_of(code)) - 6'd1;
    end
endmodule

// File: rtl/sflash_phase_seq.sv
module sflash_phase_seq
    import sfq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          keep_cs,
    input  logic [2:0]    lead_dly,
    input  logic [2:0]    trail_dly,
    input  logic          cmd_en,
    input  logic          cmd2_en,
    input  logic [1:0]    cmd_w,
    input  logic [1:0]    cmd2_w,
    input  logic [1:0]    addr_w,
    input  logic [1:0]    opt_w,
    input  logic [1:0]    data_w,
    input  logic [3:0]    addr_mask,
    input  logic [3:0]    opt_mask,
    input  logic [3:0]    data_mask,
    input  logic          dummy_en,
    input  logic [4:0]    dummy_cyc,
    input  logic [DW-1:0] cmd_reg,
    input  logic [DW-1:0] addr_reg,
    input  logic [DW-1:0] opt_reg,
    input  logic [DW-1:0] wdata,
    input  logic [3:0]    io_in,
    output logic          sck,
    output logic          cs_n,
    output logic [3:0]    io_out,
    output logic [3:0]    io_oe,
    output logic [DW-1:0] rdata,
    output logic          xfer_end,
    output logic          cs_active
);
    localparam int SW = $clog2(DW) + 1;

    state_t      state;
    phase_t      phase;
    logic        half;
    logic [5:0]  slots_left;
    logic [31:0] sh;
    logic [31:0] rd_sh;
    logic [1:0]  cur_code;
    logic [2:0]  cnt;
    logic        cs_on;

    logic [NPH-1:0]       phase_on;
    logic [NPH-1:0][1:0]  w_code;
    logic [NPH-1:0][31:0] ph_word;
    logic [NPH-1:0][2:0]  ph_bytes;
    logic                 found;
    phase_t               pick;
    logic [31:0]          ld_word;
    logic [5:0]           ld_slots;
    logic [1:0]           ld_code;
    logic [3:0]           base;
    logic                 go_next;
    logic [2:0]           cur_lines;
    logic [3:0]           lmask;
    logic                 drive;
    logic [2:0]           dbytes;
    logic [SW-1:0]        dbits;

    assign dbytes = 3'($countones(data_mask));
    assign dbits  = SW'({dbytes, 3'b000});

    assign phase_on[PH_CMD]   = cmd_en;
    assign phase_on[PH_CMD2]  = cmd2_en;
    assign phase_on[PH_ADDR]  = |addr_mask;
    assign phase_on[PH_OPT]   = |opt_mask;
    assign phase_on[PH_DUMMY] = dummy_en;
    assign phase_on[PH_DATA]  = (|data_mask) && (rd_en || wr_en);

    assign w_code[PH_CMD]   = cmd_w;
    assign w_code[PH_CMD2]  = cmd2_w;
    assign w_code[PH_ADDR]  = addr_w;
    assign w_code[PH_OPT]   = opt_w;
    assign w_code[PH_DUMMY] = 2'd0;
    assign w_code[PH_DATA]  = data_w;

    assign ph_word[PH_CMD]   = {cmd_reg[23:16], 24'h0};
    assign ph_word[PH_CMD2]  = {cmd_reg[7:0], 24'h0};
    assign ph_word[PH_ADDR]  = pack_bytes(addr_reg, addr_mask);
    assign ph_word[PH_OPT]   = pack_bytes(opt_reg, opt_mask);
    assign ph_word[PH_DUMMY] = '0;
    assign ph_word[PH_DATA]  = rd_en ? '0 : pack_bytes(wdata, data_mask);

    assign ph_bytes[PH_CMD]   = 3'd1;
    assign ph_bytes[PH_CMD2]  = 3'd1;
    assign ph_bytes[PH_ADDR]  = 3'($countones(addr_mask));
    assign ph_bytes[PH_OPT]   = 3'($countones(opt_mask));
    assign ph_bytes[PH_DUMMY] = 3'd0;
    assign ph_bytes[PH_DATA]  = dbytes;

    always_comb begin
        unique case (state)
            ST_SHIFT: base = {1'b0, phase} + 4'd1;
            ST_IDLE:  base = 4'(PH_DATA);
            default:  base = 4'd0;
        endcase
    end

    sfq_phase_pick u_pick (
        .phase_on (phase_on),
        .base     (base),
        .w_code   (w_code),
        .ph_word  (ph_word),
        .ph_bytes (ph_bytes),
        .dummy_cyc(dummy_cyc),
        .found    (found),
        .pick     (pick),
        .word     (ld_word),
        .slots    (ld_slots),
        .code     (ld_code)
    );

    assign cur_lines = lines_of(cur_code);
    assign lmask     = 4'((5'd1 << cur_lines) - 5'd1);
    assign go_next   = (state == ST_IDLE && start && cs_on)
                    || (state == ST_LEAD && cnt == 3'd0)
                    || (state == ST_SHIFT && half && slots_left == 6'd0);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase      <= PH_CMD;
            half       <= 1'b0;
            slots_left <= '0;
            sh         <= '0;
            rd_sh      <= '0;
            cur_code   <= '0;
            cnt        <= '0;
            cs_on      <= 1'b0;
            xfer_end   <= 1'b0;
            rdata      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        xfer_end <= 1'b0;
                        if (!cs_on) begin
                            cs_on <= 1'b1;
                            cnt   <= lead_dly;
                            state <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    if (cnt != 3'd0) cnt <= cnt - 3'd1;
                end
                ST_SHIFT: begin
                    if (!half) begin
                        half <= 1'b1;
                        if (phase == PH_DATA && rd_en)
                            rd_sh <= (rd_sh << cur_lines) | 32'(io_in & lmask);
                    end else begin
                        half <= 1'b0;
                        if (slots_left != 6'd0) begin
                            slots_left <= slots_left - 6'd1;
                            sh         <= sh << cur_lines;
                        end else if (phase == PH_DATA && rd_en) begin
                            rdata <= rd_sh << (SW'(DW) - dbits);
                        end
                    end
                end
                ST_TRAIL: begin
                    if (cnt != 3'd0) begin
                        cnt <= cnt - 3'd1;
                    end else begin
                        cs_on    <= 1'b0;
                        xfer_end <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (go_next) begin
                if (found) begin
                    phase      <= pick;
                    sh         <= ld_word;
                    slots_left <= ld_slots;
                    cur_code   <= ld_code;
                    half       <= 1'b0;
                    rd_sh      <= '0;
                    state      <= ST_SHIFT;
                end else if (keep_cs) begin
                    xfer_end <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    cnt   <= trail_dly;
                    state <= ST_TRAIL;
                end
            end
        end
    end

    // output process
    always_comb begin
        drive     = (state == ST_SHIFT) && (phase != PH_DUMMY) && !(phase == PH_DATA && rd_en);
        sck       = (state == ST_SHIFT) && half;
        cs_n      = !cs_on;
        cs_active = cs_on;
        io_oe     = drive ? lmask : 4'h0;
        io_out    = drive ? 4'(sh[31:28] >> (3'd4 - cur_lines)) : 4'h0;
    end

    // R9
    sck_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R2
    slot_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);

    // R2
    lane_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'h0 || io_oe == 4'h1 || io_oe == 4'h3 || io_oe == 4'hF));

    // R6
    dummy_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && phase == PH_DUMMY) |-> io_oe == 4'h0);

    // R12
    start_clears_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !cs_on) |=> !xfer_end);

    // R10
    release_flags_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> xfer_end);
endmodule

// File: tb/sflash_phase_seq_test.sv
module sflash_phase_seq_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start, rd_en, wr_en, keep_cs, cmd_en, cmd2_en, dummy_en;
    logic [2:0] lead_dly, trail_dly;
    logic [1:0] cmd_w, cmd2_w, addr_w, opt_w, data_w;
    logic [3:0] addr_mask, opt_mask, data_mask, io_in;
    logic [4:0] dummy_cyc;
    logic [31:0] cmd_reg, addr_reg, opt_reg, wdata;
    logic sck, cs_n, xfer_end, cs_active;
    logic [3:0] io_out, io_oe;
    logic [31:0] rdata;

    sflash_phase_seq uut (.*);

    int checks = 0, fails = 0;
    int cyc = 0, rise_cnt = 0, rd_start = 0, rd_L = 1;
    int t_cs_fall = -1, t_first = -1, t_last = -1, t_cs_rise = -1;
    bit rd_active = 0;
    logic cs_prev = 1'b1;
    logic [31:0] rpat = '0;
    logic [3:0] got_oe[0:255], got_out[0:255], exp_oe[0:255], exp_out[0:255];
    int n_exp = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [31:0] t;
        cyc++;
        if (rd_active && rise_cnt >= rd_start) begin
            t = (rpat << ((rise_cnt - rd_start) * rd_L)) >> (32 - rd_L);
            io_in = t[3:0];
        end else io_in = 4'h0;
        if (sck) begin
            if (rise_cnt < 256) begin
                got_oe[rise_cnt]  = io_oe;
                got_out[rise_cnt] = io_out;
            end
            if (rise_cnt == 0) t_first = cyc;
            t_last = cyc;
            rise_cnt++;
        end
        if (cs_prev && !cs_n) t_cs_fall = cyc;
        if (!cs_prev && cs_n) t_cs_rise = cyc;
        cs_prev = cs_n;
    end

    function automatic int lines(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] bpack(input logic [31:0] src, input logic [3:0] m);
        logic [31:0] w = '0;
        int n = 0;
        for (int i = 3; i >= 0; i--)
            if (m[i]) begin
                w = (w << 8) | ((src >> (8*i)) & 32'hFF);
                n++;
            end
        return (n == 0) ? 32'h0 : (w << (8*(4-n)));
    endfunction

    task automatic add_ph(logic [31:0] w, int nbits, int L, bit drv);
        for (int k = 0; k < nbits / L; k++) begin
            logic [31:0] t = (w << (k*L)) >> (32 - L);
            exp_oe[n_exp]  = drv ? 4'((1 << L) - 1) : 4'h0;
            exp_out[n_exp] = t[3:0];
            n_exp++;
        end
    endtask

    task automatic run_xfer;
        int w = 0;
        rise_cnt = 0; t_first = -1; t_cs_rise = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(xfer_end == 1'b0, "R12 end flag cleared after start", 32'(xfer_end), 0);
        while (!xfer_end && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 3000, "R12 transfer completes", w, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_stream(string tag);
        bit ok = 1;
        int bad = 0;
        chk(rise_cnt == n_exp, {tag, " R1 slot count"}, rise_cnt, n_exp);
        for (int k = 0; k < n_exp && k < 256; k++)
            if (got_oe[k] !== exp_oe[k] || ((got_out[k] ^ exp_out[k]) & exp_oe[k]) != 0) begin
                if (ok) bad = k;
                ok = 0;
            end
        chk(ok, {tag, " R1 R2 R3 R4 R5 R6 R7 slot content"},
            {got_oe[bad], got_out[bad], 24'(bad)}, {exp_oe[bad], exp_out[bad], 24'(bad)});
    endtask

    initial begin
        #700000;
        fails++;
        $display("FAIL watchdog R12 actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; rd_en = 0; wr_en = 0; keep_cs = 0;
        cmd_en = 0; cmd2_en = 0; dummy_en = 0; lead_dly = 0; trail_dly = 0;
        cmd_w = 0; cmd2_w = 0; addr_w = 0; opt_w = 0; data_w = 0;
        addr_mask = 0; opt_mask = 0; data_mask = 0; dummy_cyc = 0;
        cmd_reg = 0; addr_reg = 0; opt_reg = 0; wdata = 0; io_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13
        chk(cs_n == 1'b1, "R13 cs_n idle", 32'(cs_n), 1);
        chk(sck == 1'b0, "R13 sck idle", 32'(sck), 0);
        chk(io_oe == 4'h0, "R13 io_oe idle", 32'(io_oe), 0);
        chk(xfer_end == 1'b0 && cs_active == 1'b0, "R13 flags idle",
            {30'h0, xfer_end, cs_active}, 0);

        for (int w = 0; w < 3; w++)
            for (int nb = 1; nb <= 4; nb++)
                for (int dir = 0; dir < 2; dir++) begin
                    int ob;
                    ob = (nb == 2) ? 0 : 5 - nb;
                    cmd_en = 1; cmd2_en = (nb % 2 == 0);
                    cmd_reg = {8'h0, 8'(8'hA0 + nb), 8'h00, 8'(8'h50 + w)};
                    cmd_w = (w == 2) ? 2'd2 : 2'd0; cmd2_w = 2'(w); addr_w = 2'(w);
                    opt_w = 2'((w + 1) % 3); data_w = 2'(w);
                    addr_mask = (nb == 1) ? 4'hF : (nb == 2) ? 4'h7 : (nb == 3) ? 4'h0 : 4'h5;
                    opt_mask = (ob == 0) ? 4'h0 : 4'(4'hF << (4 - ob));
                    dummy_en = (nb >= 3); dummy_cyc = 5'(nb*5 + w);
                    data_mask = 4'(4'hF << (4 - nb));
                    lead_dly = 3'(nb + w); trail_dly = 3'(7 - nb - w);
                    addr_reg = 32'h1234_5678 ^ (nb << 20);
                    opt_reg = 32'h9ABC_DEF0 + w;
                    wdata = 32'hC3A5_0000 | (nb*17 + w);
                    rpat = 32'h6D2B_F18E ^ {w[3:0], nb[3:0], 24'h5A0C3};
                    rd_en = (dir == 1); wr_en = (dir == 0); keep_cs = 0;
                    n_exp = 0;
                    add_ph({cmd_reg[23:16], 24'h0}, 8, lines(cmd_w), 1);
                    if (cmd2_en) add_ph({cmd_reg[7:0], 24'h0}, 8, lines(cmd2_w), 1);
                    if (addr_mask != 0) add_ph(bpack(addr_reg, addr_mask), 8*$countones(addr_mask), lines(addr_w), 1);
                    if (opt_mask != 0) add_ph(bpack(opt_reg, opt_mask), 8*ob, lines(opt_w), 1);
                    if (dummy_en) add_ph(32'h0, int'(dummy_cyc) + 1, 1, 0);
                    rd_start = n_exp; rd_L = lines(data_w);
                    add_ph(dir ? 32'h0 : bpack(wdata, data_mask), nb*8, rd_L, !dir);
                    rd_active = dir;
                    run_xfer();
                    rd_active = 0;
                    chk_stream(dir ? "read" : "write");
                    chk(t_first - t_cs_fall == int'(lead_dly) + 2, "R9 lead gap",
                        t_first - t_cs_fall, int'(lead_dly) + 2);
                    chk(t_cs_rise - t_last == int'(trail_dly) + 2, "R10 trail gap",
                        t_cs_rise - t_last, int'(trail_dly) + 2);
                    chk(cs_n == 1'b1 && cs_active == 1'b0, "R12 select released",
                        {cs_n, cs_active}, 2);
                    if (dir)
                        chk(rdata == (rpat & ~(32'hFFFF_FFFF >> (nb*8))), "R8 read data",
                            rdata, rpat & ~(32'hFFFF_FFFF >> (nb*8)));
                end

        // R11 kept select: first chunk full, second chunk data only
        cmd_en = 1; cmd2_en = 0; cmd_w = 0; addr_mask = 4'hF; addr_w = 2; opt_mask = 0;
        dummy_en = 0; data_mask = 4'hF; data_w = 1; rd_en = 0; wr_en = 1;
        cmd_reg = 32'h0003_0000; addr_reg = 32'h0001_0200; wdata = 32'h1122_3344;
        lead_dly = 2; trail_dly = 4; keep_cs = 1;
        n_exp = 0;
        add_ph(32'h0300_0000, 8, 1, 1);
        add_ph(32'h0001_0200, 32, 4, 1);
        add_ph(32'h1122_3344, 32, 2, 1);
        run_xfer();
        chk_stream("R11 first chunk");
        chk(cs_n == 1'b0 && cs_active == 1'b1, "R11 select held", {cs_n, cs_active}, 1);
        chk(xfer_end == 1'b1, "R11 end flag with held select", 32'(xfer_end), 1);
        t_cs_fall = -1;
        wdata = 32'hDEAD_BEEF; keep_cs = 0; data_w = 2;
        n_exp = 0;
        add_ph(32'hDEAD_BEEF, 32, 4, 1);
        run_xfer();
        chk_stream("R11 continuation");
        chk(t_cs_fall == -1, "R11 no new select", t_cs_fall, 32'hFFFF_FFFF);
        chk(t_cs_rise - t_last == 6, "R10 trail after continuation", t_cs_rise - t_last, 6);
        chk(cs_n == 1'b1, "R11 release after last chunk", 32'(cs_n), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule